// File: doc/BRIEF.md
# Receive Watermark Pause Controller

This block decides when a receive path should ask its link partner to stop or resume sending. It compares the receive buffer fill level against a high and a low threshold. When the level climbs past the high threshold, it asks a frame transmitter to send an 802.3x PAUSE frame that carries the configured pause time (XOFF). For as long as that stop state lasts, it repeats the XOFF each time half of the pause time has passed. When the level falls under the low threshold, it asks for a PAUSE frame with a pause time of zero (XON). A state bit provides hysteresis, so a level that moves about between the two thresholds produces no extra frames.

The configuration is checked all the time. If the pause time is zero, or the thresholds are not legal while transmit pause is in use, the block flags an error and requests nothing. When transmit pause is not in use, or the high threshold is zero, the effective thresholds are replaced by fixed values: the high one becomes the buffer size less a 24576-byte guard and the low one becomes zero. Requests leave the block over a valid/acknowledge handshake. The 32-bit word in each request already has the pause time placed in its upper half.

Top module: `rxwm_pause_ctrl`

## Requirements
- R1: During and right after reset, `req_valid` and `xoff_active` are 0, and a reset in the middle of a request drops that request.
- R2: When `cfg_pause_time` is 0, `cfg_err` is 1 in the same cycle and no request is raised.
- R3: When `tx_pause_en` is 1 and `cfg_high_mark` is nonzero, a `cfg_low_mark` of 0 or a low mark not strictly below the high mark sets `cfg_err` combinationally and blocks all requests. Illegal marks do not set `cfg_err` while `tx_pause_en` is 0.
- R4: With no request pending and `xoff_active` at 0, a fill level strictly above the effective high mark raises `req_valid` at the next clock edge. The request word is `{cfg_pause_time, 16'h0000}` and `xoff_active` becomes 1.
- R5: With `xoff_active` at 1 and no request pending, a fill level strictly below the effective low mark raises a request with word 0 (XON) at the next edge, and `xoff_active` returns to 0.
- R6: A fill level equal to either mark triggers nothing. Moving between the marks raises no new XOFF or XON.
- R7: While `xoff_active` is 1, a fresh XOFF is requested once `quanta_tick` has pulsed floor(`cfg_pause_time`/2) times since the previous XOFF was issued (at least one pulse). The request comes at the edge after the last counted pulse.
- R8: Only one request is outstanding at a time. `req_valid` and `req_word` hold steady until `req_ack` is sampled high, and a later decision is issued no sooner than the edge after that acknowledge.
- R9: When `tx_pause_en` is 0 or `cfg_high_mark` is 0, `eff_low_mark` is 0 and `eff_high_mark` is `cfg_buf_size` - 24576 (0 if the buffer is smaller). No request is raised in that case and `xoff_active` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_level | input | LVL_W | Current receive buffer fill in bytes |
| cfg_high_mark | input | LVL_W | Configured high threshold |
| cfg_low_mark | input | LVL_W | Configured low threshold |
| cfg_pause_time | input | 16 | Pause time in 512-bit-time quanta |
| cfg_buf_size | input | LVL_W | Receive buffer size in bytes |
| tx_pause_en | input | 1 | Negotiated permission to send pause frames |
| quanta_tick | input | 1 | One-cycle pulse per elapsed pause quantum |
| req_ack | input | 1 | Transmitter accepts the current request |
| req_valid | output | 1 | Pause frame request pending |
| req_word | output | 32 | Pause register word, pause time in bits 31:16 |
| xoff_active | output | 1 | Stop state currently asserted |
| cfg_err | output | 1 | Configuration is illegal |
| eff_high_mark | output | LVL_W | High threshold in effect |
| eff_low_mark | output | LVL_W | Low threshold in effect |

## Verification
`cfg_err` and the two effective marks are combinational, so the bench checks them one time unit after it drives the configuration, before any clock edge. A request decision is registered once: a fill change driven on a falling edge shows up on `req_valid`, `req_word` and `xoff_active` at the next falling edge. An acknowledge takes effect at the edge where it is sampled, and the next queued decision appears one edge after that. A refresh is due one edge after the counted tick that reaches half the pause time, so the bench checks for its absence after one tick too few and for its presence one cycle after the last tick.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;

  localparam int PT_W = 16;

  // High threshold used when the marks are not in use: buffer less guard, floored at zero.
  function automatic logic [31:0] forced_high(input logic [31:0] buf_bytes,
                                              input logic [31:0] guard);
    return (buf_bytes > guard) ? (buf_bytes - guard) : 32'd0;
  endfunction

  // Marks are illegal when the low one is zero or not strictly below the high one.
  function automatic logic marks_illegal(input logic [31:0] hi, input logic [31:0] lo);
    return (lo == 32'd0) || (lo >= hi);
  endfunction

  // Refresh interval: half the pause time, never below one quantum.
  function automatic logic [PT_W-1:0] refresh_span(input logic [PT_W-1:0] pt);
    logic [PT_W-1:0] half;
    half = pt >> 1;
    return (half == '0) ? PT_W'(1) : half;
  endfunction

  // Pause register word: pause time in upper half for XOFF, all zero for XON.
  function automatic logic [31:0] frame_word(input logic [PT_W-1:0] pt, input logic is_xoff);
    return is_xoff ? {pt, 16'h0000} : 32'h0000_0000;
  endfunction

endpackage

// File: rtl/rxwm_cfg_check.sv
module rxwm_cfg_check
  import rxwm_pkg::*;
#(
  parameter int LVL_W = 20,
  parameter int GUARD_BYTES = 24576
) (
  input  logic             tx_pause_en,
  input  logic [LVL_W-1:0] cfg_high_mark,
  input  logic [LVL_W-1:0] cfg_low_mark,
  input  logic [PT_W-1:0]  cfg_pause_time,
  input  logic [LVL_W-1:0] cfg_buf_size,
  output logic             cfg_err,
  output logic             marks_live,
  output logic [LVL_W-1:0] eff_high_mark,
  output logic [LVL_W-1:0] eff_low_mark
);

  logic uses_marks;
  logic bad_marks;
  logic zero_time;

  always_comb begin
    uses_marks = tx_pause_en && (cfg_high_mark != '0);
    bad_marks  = marks_illegal(32'(cfg_high_mark), 32'(cfg_low_mark));
    zero_time  = (cfg_pause_time == '0);
    cfg_err    = zero_time || (uses_marks && bad_marks);
    marks_live = uses_marks && !cfg_err;
    if (uses_marks) begin
      eff_high_mark = cfg_high_mark;
      eff_low_mark  = cfg_low_mark;
    end else begin
      eff_high_mark = LVL_W'(forced_high(32'(cfg_buf_size), 32'(GUARD_BYTES)));
      eff_low_mark  = '0;
    end
  end

endmodule

// File: rtl/rxwm_refresh_timer.sv
module rxwm_refresh_timer
  import rxwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic            tick,
  input  logic [PT_W-1:0] span,
  output logic            due
);

  logic [PT_W-1:0] quanta_cnt;
  logic            at_max;

  assign at_max = (quanta_cnt == {PT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quanta_cnt <= '0;
    end else if (restart || !run) begin
      quanta_cnt <= '0;
    end else if (tick && !at_max) begin
      quanta_cnt <= quanta_cnt + 1'b1;
    end
  end

  assign due = run && (quanta_cnt >= span);

endmodule

// File: rtl/rxwm_req_port.sv
module rxwm_req_port
  import rxwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic            issue_xoff,
  input  logic [PT_W-1:0] pause_time,
  input  logic            req_ack,
  output logic            req_valid,
  output logic [31:0]     req_word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_word  <= '0;
    end else if (issue) begin
      req_valid <= 1'b1;
      req_word  <= frame_word(pause_time, issue_xoff);
    end else if (req_valid && req_ack) begin
      req_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rxwm_pause_ctrl.sv
module rxwm_pause_ctrl
  import rxwm_pkg::*;
#(
  parameter int LVL_W = 20,
  parameter int GUARD_BYTES = 24576
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] cfg_high_mark,
  input  logic [LVL_W-1:0] cfg_low_mark,
  input  logic [15:0]      cfg_pause_time,
  input  logic [LVL_W-1:0] cfg_buf_size,
  input  logic             tx_pause_en,
  input  logic             quanta_tick,
  input  logic             req_ack,
  output logic             req_valid,
  output logic [31:0]      req_word,
  output logic             xoff_active,
  output logic             cfg_err,
  output logic [LVL_W-1:0] eff_high_mark,
  output logic [LVL_W-1:0] eff_low_mark
);

  logic marks_live;
  logic above_high;
  logic below_low;
  logic slot_free;
  logic refresh_due;
  logic evt_xoff;
  logic evt_xon;
  logic evt_refresh;
  logic evt_issue;
  logic evt_issue_xoff;
  logic xoff_q;
  logic [PT_W-1:0] span;

  rxwm_cfg_check #(.LVL_W(LVL_W), .GUARD_BYTES(GUARD_BYTES)) u_cfg (
    .tx_pause_en   (tx_pause_en),
    .cfg_high_mark (cfg_high_mark),
    .cfg_low_mark  (cfg_low_mark),
    .cfg_pause_time(cfg_pause_time),
    .cfg_buf_size  (cfg_buf_size),
    .cfg_err       (cfg_err),
    .marks_live    (marks_live),
    .eff_high_mark (eff_high_mark),
    .eff_low_mark  (eff_low_mark)
  );

  // Decision events, named for the checker.
  always_comb begin
    above_high     = fill_level > eff_high_mark;
    below_low      = fill_level < eff_low_mark;
    slot_free      = marks_live && !req_valid;
    evt_xoff       = slot_free && !xoff_q && above_high;
    evt_xon        = slot_free && xoff_q && below_low;
    evt_refresh    = slot_free && xoff_q && !below_low && refresh_due;
    evt_issue      = evt_xoff || evt_xon || evt_refresh;
    evt_issue_xoff = evt_xoff || evt_refresh;
    span           = refresh_span(cfg_pause_time);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xoff_q <= 1'b0;
    end else if (!marks_live) begin
      xoff_q <= 1'b0;
    end else if (evt_xoff) begin
      xoff_q <= 1'b1;
    end else if (evt_xon) begin
      xoff_q <= 1'b0;
    end
  end

  assign xoff_active = xoff_q;

  rxwm_refresh_timer u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (xoff_q),
    .restart(evt_issue_xoff),
    .tick   (quanta_tick),
    .span   (span),
    .due    (refresh_due)
  );

  rxwm_req_port u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (evt_issue),
    .issue_xoff(evt_issue_xoff),
    .pause_time(cfg_pause_time),
    .req_ack   (req_ack),
    .req_valid (req_valid),
    .req_word  (req_word)
  );

endmodule

// File: rtl/rxwm_pause_ctrl_chk.sv
module rxwm_pause_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ack,
  input logic [31:0] req_word,
  input logic        xoff_active,
  input logic        cfg_err,
  input logic        tx_pause_en
);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack |=> req_valid && $stable(req_word));

  // R2
  no_req_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && cfg_err |=> !req_valid);

  // R4
  word_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_word[15:0] == 16'h0000);

  // R4
  xoff_sets_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && req_word != 32'h0 |-> xoff_active);

  // R5
  xon_clears_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && req_word == 32'h0 |-> !xoff_active);

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && !tx_pause_en |=> !req_valid);

endmodule

bind rxwm_pause_ctrl rxwm_pause_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ack    (req_ack),
  .req_word   (req_word),
  .xoff_active(xoff_active),
  .cfg_err    (cfg_err),
  .tx_pause_en(tx_pause_en)
);

// File: tb/rxwm_pause_ctrl_tb.sv
module rxwm_pause_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LW = 20;

  typedef struct packed {
    logic          tx;
    logic [LW-1:0] hi;
    logic [LW-1:0] lo;
    logic [15:0]   pt;
    logic [LW-1:0] bsz;
  } cfg_vec_t;

  localparam cfg_vec_t VECS [8] = '{
    '{1'b1, 20'd1000, 20'd200,  16'd8, 20'd65536},
    '{1'b1, 20'd1000, 20'd1000, 16'd8, 20'd65536},
    '{1'b1, 20'd1000, 20'd0,    16'd8, 20'd65536},
    '{1'b1, 20'd1000, 20'd200,  16'd0, 20'd65536},
    '{1'b0, 20'd1000, 20'd200,  16'd8, 20'd65536},
    '{1'b1, 20'd0,    20'd0,    16'd8, 20'd30000},
    '{1'b0, 20'd1000, 20'd200,  16'd8, 20'd20000},
    '{1'b0, 20'd1000, 20'd2000, 16'd8, 20'd65536}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] fill_level = '0;
  logic [LW-1:0] cfg_high_mark = '0;
  logic [LW-1:0] cfg_low_mark = '0;
  logic [15:0]   cfg_pause_time = '0;
  logic [LW-1:0] cfg_buf_size = '0;
  logic          tx_pause_en = 1'b0;
  logic          quanta_tick = 1'b0;
  logic          req_ack = 1'b0;
  logic          req_valid;
  logic [31:0]   req_word;
  logic          xoff_active;
  logic          cfg_err;
  logic [LW-1:0] eff_high_mark;
  logic [LW-1:0] eff_low_mark;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxwm_pause_ctrl #(.LVL_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fill_level(fill_level),
    .cfg_high_mark(cfg_high_mark), .cfg_low_mark(cfg_low_mark),
    .cfg_pause_time(cfg_pause_time), .cfg_buf_size(cfg_buf_size),
    .tx_pause_en(tx_pause_en), .quanta_tick(quanta_tick), .req_ack(req_ack),
    .req_valid(req_valid), .req_word(req_word), .xoff_active(xoff_active),
    .cfg_err(cfg_err), .eff_high_mark(eff_high_mark), .eff_low_mark(eff_low_mark)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_once();
    quanta_tick = 1'b1;
    step(1);
    quanta_tick = 1'b0;
  endtask

  task automatic ack_once();
    req_ack = 1'b1;
    step(1);
    req_ack = 1'b0;
  endtask

  task automatic set_cfg(input logic tx, input int hi, input int lo, input int pt, input int bsz);
    tx_pause_en    = tx;
    cfg_high_mark  = LW'(hi);
    cfg_low_mark   = LW'(lo);
    cfg_pause_time = 16'(pt);
    cfg_buf_size   = LW'(bsz);
  endtask

  // Expected config outputs, restated from R2, R3 and R9.
  function automatic logic exp_err(input cfg_vec_t v);
    logic marks_ok;
    marks_ok = (v.lo != 0) && (v.lo < v.hi);
    if (v.pt == 0) return 1'b1;
    if (!v.tx || v.hi == 0) return 1'b0;
    return !marks_ok;
  endfunction

  function automatic logic [LW-1:0] exp_hi(input cfg_vec_t v);
    int room;
    if (v.tx && v.hi != 0) return v.hi;
    room = int'(v.bsz) - 24576;
    return (room < 0) ? '0 : LW'(room);
  endfunction

  function automatic logic [LW-1:0] exp_lo(input cfg_vec_t v);
    return (v.tx && v.hi != 0) ? v.lo : '0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(2);
    // R1 reset state
    chk("R1 req_valid in reset", 32'(req_valid), 32'd0);
    chk("R1 xoff_active in reset", 32'(xoff_active), 32'd0);
    rst_n = 1'b1;
    step(1);

    // Configuration table (R2, R3, R9)
    for (int i = 0; i < 8; i++) begin
      set_cfg(VECS[i].tx, int'(VECS[i].hi), int'(VECS[i].lo), int'(VECS[i].pt), int'(VECS[i].bsz));
      #1;
      chk($sformatf("R2/R3 cfg_err vec%0d", i), 32'(cfg_err), 32'(exp_err(VECS[i])));
      chk($sformatf("R9 eff_high vec%0d", i), 32'(eff_high_mark), 32'(exp_hi(VECS[i])));
      chk($sformatf("R9 eff_low vec%0d", i), 32'(eff_low_mark), 32'(exp_lo(VECS[i])));
      step(1);
      chk($sformatf("R2 no request vec%0d", i), 32'(req_valid), 32'd0);
    end

    set_cfg(1'b1, 1000, 200, 8, 65536);
    fill_level = 20'd500;
    step(2);
    chk("R6 between marks idle", 32'(req_valid), 32'd0);
    fill_level = 20'd1000;
    step(2);
    chk("R6 equal to high mark", 32'(req_valid), 32'd0);

    fill_level = 20'd1001;
    step(1);
    chk("R4 xoff valid", 32'(req_valid), 32'd1);
    chk("R4 xoff word", req_word, 32'h0008_0000);
    chk("R4 xoff state", 32'(xoff_active), 32'd1);
    step(3);
    chk("R8 held until ack", 32'(req_valid), 32'd1);
    chk("R8 word held", req_word, 32'h0008_0000);
    ack_once();
    chk("R8 ack drops valid", 32'(req_valid), 32'd0);

    fill_level = 20'd500;
    step(3);
    chk("R6 no repeat between marks", 32'(req_valid), 32'd0);
    fill_level = 20'd200;
    step(2);
    chk("R6 equal to low mark", 32'(req_valid), 32'd0);
    fill_level = 20'd500;

    // R7 refresh after pt/2 = 4 quanta
    repeat (3) tick_once();
    step(1);
    chk("R7 no refresh at 3 quanta", 32'(req_valid), 32'd0);
    tick_once();
    step(1);
    chk("R7 refresh valid", 32'(req_valid), 32'd1);
    chk("R7 refresh word", req_word, 32'h0008_0000);
    ack_once();

    fill_level = 20'd150;
    step(1);
    chk("R5 xon valid", 32'(req_valid), 32'd1);
    chk("R5 xon word", req_word, 32'h0);
    chk("R5 xon clears state", 32'(xoff_active), 32'd0);
    ack_once();
    step(3);
    chk("R6 no repeat xon", 32'(req_valid), 32'd0);

    // R8 second decision waits for ack
    fill_level = 20'd1500;
    step(1);
    fill_level = 20'd100;
    step(2);
    chk("R8 pending xoff kept", req_word, 32'h0008_0000);
    ack_once();
    chk("R8 no issue at ack edge", 32'(req_valid), 32'd0);
    step(1);
    chk("R8 queued xon after ack", 32'(req_valid), 32'd1);
    chk("R8 queued xon word", req_word, 32'h0);
    ack_once();

    // R2 zero pause time blocks
    set_cfg(1'b1, 1000, 200, 0, 65536);
    fill_level = 20'd1500;
    step(3);
    chk("R2 zero time no request", 32'(req_valid), 32'd0);
    chk("R2 zero time err", 32'(cfg_err), 32'd1);
    // R3 low equal to high blocks
    set_cfg(1'b1, 1000, 1000, 8, 65536);
    step(3);
    chk("R3 bad marks no request", 32'(req_valid), 32'd0);
    chk("R3 bad marks state", 32'(xoff_active), 32'd0);
    // R9 disabled
    set_cfg(1'b0, 1000, 200, 8, 65536);
    step(3);
    chk("R9 disabled no request", 32'(req_valid), 32'd0);
    chk("R9 forced high", 32'(eff_high_mark), 32'd40960);

    // R9 disabling clears state
    set_cfg(1'b1, 1000, 200, 8, 65536);
    step(1);
    ack_once();
    chk("R9 state set before disable", 32'(xoff_active), 32'd1);
    tx_pause_en = 1'b0;
    step(1);
    chk("R9 disable clears state", 32'(xoff_active), 32'd0);

    // R1 reset mid request
    tx_pause_en = 1'b1;
    step(1);
    chk("R1 request before reset", 32'(req_valid), 32'd1);
    rst_n = 1'b0;
    step(1);
    chk("R1 reset drops request", 32'(req_valid), 32'd0);
    chk("R1 reset clears state", 32'(xoff_active), 32'd0);
    fill_level = 20'd500;
    rst_n = 1'b1;
    step(1);

    // R7 minimum span of one quantum with pause time 1
    set_cfg(1'b1, 1000, 200, 1, 65536);
    fill_level = 20'd1500;
    step(1);
    chk("R7 pt1 xoff word", req_word, 32'h0001_0000);
    ack_once();
    fill_level = 20'd500;
    step(1);
    chk("R7 pt1 idle before tick", 32'(req_valid), 32'd0);
    tick_once();
    step(1);
    chk("R7 pt1 refresh after one tick", 32'(req_valid), 32'd1);
    ack_once();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule